// File: doc/BRIEF.md
# Paged MDIO Management Slave

This block is the management end of a two-wire serial management link in the clause-22 style. It runs directly on the management clock, samples the data line on each rising clock edge, and recognises read and write frames that carry its strapped 5-bit device address. It holds a 32-entry file of 16-bit registers. The data line is open-drain: the block never drives it high. It either pulls it low through an output enable or lets the external pull-up hold it high.

Entry 31 is a page selector. Entries 0 to 15 and entry 31 are shared by all pages. Entries 16 to 30 point to a separate bank for each page, so the same address reaches different storage depending on the page currently selected. After every frame the parser goes back to hunting for a start pattern. A frame may follow an idle line of any length, or none at all.

Top module: `mdio_slave_paged`

## Requirements
- R1: After reset, asynchronous or mid-run, every register reads 0, the page is 0 and `mdio_oe_o` is low.
- R2: A write frame (start 01, opcode 01, address, register, turnaround, 16 data bits MSB first) stores the data, and a later read frame of the same register returns it.
- R3: On a read, the line is released during the first turnaround bit period and driven low during the second.
- R4: Read data leaves MSB first, one bit per clock. A 0 bit asserts `mdio_oe_o` and a 1 bit releases the line. The line is released again after the last data bit.
- R5: A frame whose device address differs from `phy_addr_i` changes no register and never drives the line.
- R6: A frame with opcode 00 or 11 changes no register and never drives the line.
- R7: Bit 0 of register 31 selects the page. Registers 16 to 30 hold separate contents on page 0 and page 1.
- R8: Registers 0 to 15 and register 31 read and write the same storage whatever page is selected.
- R9: A frame is recognised after a run of idle ones of any length, including none, and straight after a previous frame.
- R10: During a write frame the line is never driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc_i | input | 1 | Management clock; all state changes on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mdio_i | input | 1 | Sampled state of the shared data line |
| phy_addr_i | input | 5 | Strapped device address |
| mdio_oe_o | output | 1 | Pull the data line low when high |

## Verification
Write-then-read pairs use the all-ones, alternating and sparse data values. This shows that bit order and polarity are right on both directions of the line. Pairs aimed at register 16 on each page, at shared registers after a page change, and at the page register itself show the banked storage apart from the shared storage. Frames with a foreign device address, frames with a reserved opcode, and frames with no idle ones before them or with long runs of idle ones show that decoding depends only on the start pattern and on matching fields.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int DATA_W     = 16;
  localparam int ADDR_W     = 5;
  localparam int NUM_REGS   = 1 << ADDR_W;
  localparam int NUM_SHARED = NUM_REGS / 2;
  localparam int NUM_PAGED  = NUM_REGS - NUM_SHARED - 1;

  localparam logic [ADDR_W-1:0] PAGE_REG = ADDR_W'(NUM_REGS - 1);

  // bit positions within the 32-bit frame (start bits at 0 and 1)
  localparam logic [4:0] POS_FIRST_HDR = 5'd2;
  localparam logic [4:0] POS_DECODE    = 5'd13;
  localparam logic [4:0] POS_TA_HI     = 5'd14;
  localparam logic [4:0] POS_DATA_LO   = 5'd15;
  localparam logic [4:0] POS_DATA_HI   = 5'd30;
  localparam logic [4:0] POS_LAST      = 5'd31;

  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;

  typedef enum logic [1:0] {ST_HUNT, ST_START, ST_BODY} mdio_st_e;
endpackage

// File: rtl/mdio_frame_parser.sv
module mdio_frame_parser
  import mdio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mdio_i,
  input  logic [ADDR_W-1:0] phy_addr_i,
  output logic              rd_load_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              ta_drive_o,
  output logic              tx_shift_o,
  output mdio_st_e          st_o,
  output logic [4:0]        pos_o,
  output logic              rd_act_o,
  output logic              wr_act_o
);
  mdio_st_e          st_q;
  logic [4:0]        pos_q;
  logic [DATA_W-2:0] sh_q;
  logic              rd_q, wr_q;
  logic [ADDR_W-1:0] addr_q;

  logic [11:0] hdr;
  logic        decode, addr_hit, in_body;

  assign hdr      = {sh_q[10:0], mdio_i};
  assign in_body  = (st_q == ST_BODY);
  assign decode   = in_body && (pos_q == POS_DECODE);
  assign addr_hit = (hdr[9:5] == phy_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_HUNT;
      pos_q  <= '0;
      sh_q   <= '0;
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      unique case (st_q)
        ST_HUNT:  if (!mdio_i) st_q <= ST_START;
        ST_START: if (mdio_i) begin
          st_q  <= ST_BODY;
          pos_q <= POS_FIRST_HDR;
          rd_q  <= 1'b0;
          wr_q  <= 1'b0;
        end
        ST_BODY: begin
          pos_q <= pos_q + 5'd1;
          sh_q  <= {sh_q[DATA_W-3:0], mdio_i};
          if (decode) begin
            rd_q   <= addr_hit && (hdr[11:10] == OP_READ);
            wr_q   <= addr_hit && (hdr[11:10] == OP_WRITE);
            addr_q <= hdr[4:0];
          end
          if (pos_q == POS_LAST) begin
            st_q <= ST_HUNT;
            rd_q <= 1'b0;
            wr_q <= 1'b0;
          end
        end
        default: st_q <= ST_HUNT;
      endcase
    end
  end

  assign rd_load_o  = decode && addr_hit && (hdr[11:10] == OP_READ);
  assign rd_addr_o  = hdr[4:0];
  assign wr_en_o    = in_body && (pos_q == POS_LAST) && wr_q;
  assign wr_addr_o  = addr_q;
  assign wr_data_o  = {sh_q, mdio_i};
  assign ta_drive_o = in_body && (pos_q == POS_TA_HI) && rd_q;
  assign tx_shift_o = in_body && (pos_q >= POS_DATA_LO) && (pos_q <= POS_DATA_HI) && rd_q;
  assign st_o       = st_q;
  assign pos_o      = pos_q;
  assign rd_act_o   = rd_q;
  assign wr_act_o   = wr_q;
endmodule

// File: rtl/mdio_page_regs.sv
module mdio_page_regs
  import mdio_pkg::*;
#(
  parameter int NUM_PAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  localparam int PAGE_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;
  localparam int IDX_W  = ADDR_W - 1;

  logic [DATA_W-1:0] shared_q [NUM_SHARED];
  logic [DATA_W-1:0] page_reg_q;
  logic [PAGE_W-1:0] page_idx;
  logic [NUM_PAGES-1:0][DATA_W-1:0] page_rd;
  logic [IDX_W-1:0]  rd_pidx;

  assign page_idx = (int'(page_reg_q[PAGE_W-1:0]) < NUM_PAGES) ? page_reg_q[PAGE_W-1:0] : '0;
  assign rd_pidx  = (rd_addr_i[IDX_W-1:0] == IDX_W'(NUM_PAGED)) ? '0 : rd_addr_i[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_SHARED; i++) shared_q[i] <= '0;
      page_reg_q <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == PAGE_REG)   page_reg_q <= wr_data_i;
      else if (!wr_addr_i[IDX_W])  shared_q[wr_addr_i[IDX_W-1:0]] <= wr_data_i;
    end
  end

  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
    logic [DATA_W-1:0] bank_q [NUM_PAGED];
    logic              sel;
    assign sel = wr_en_i && (page_idx == PAGE_W'(p)) && wr_addr_i[IDX_W]
                 && (wr_addr_i != PAGE_REG);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < NUM_PAGED; i++) bank_q[i] <= '0;
      end else if (sel) begin
        bank_q[wr_addr_i[IDX_W-1:0]] <= wr_data_i;
      end
    end
    assign page_rd[p] = bank_q[rd_pidx];
  end

  always_comb begin
    if (rd_addr_i == PAGE_REG)  rd_data_o = page_reg_q;
    else if (!rd_addr_i[IDX_W]) rd_data_o = shared_q[rd_addr_i[IDX_W-1:0]];
    else                        rd_data_o = page_rd[page_idx];
  end
endmodule

// File: rtl/mdio_tx_driver.sv
module mdio_tx_driver
  import mdio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ta_drive_i,
  input  logic              shift_i,
  output logic              oe_o
);
  logic [DATA_W-1:0] tx_q;
  logic              oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
      oe_q <= 1'b0;
    end else begin
      if (load_i)       tx_q <= data_i;
      else if (shift_i) tx_q <= {tx_q[DATA_W-2:0], 1'b0};
      // open drain: a 0 bit pulls low, a 1 bit releases
      if (ta_drive_i)   oe_q <= 1'b1;
      else if (shift_i) oe_q <= ~tx_q[DATA_W-1];
      else              oe_q <= 1'b0;
    end
  end

  assign oe_o = oe_q;
endmodule

// File: rtl/mdio_slave_paged.sv
module mdio_slave_paged
  import mdio_pkg::*;
#(
  parameter int NUM_PAGES = 2
) (
  input  logic              mdc_i,
  input  logic              rst_ni,
  input  logic              mdio_i,
  input  logic [ADDR_W-1:0] phy_addr_i,
  output logic              mdio_oe_o
);
  logic              rd_load, wr_en, ta_drive, tx_shift, rd_act, wr_act;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data;
  mdio_st_e          st;
  logic [4:0]        pos;

  mdio_frame_parser u_parser (
    .clk_i      (mdc_i),
    .rst_ni     (rst_ni),
    .mdio_i     (mdio_i),
    .phy_addr_i (phy_addr_i),
    .rd_load_o  (rd_load),
    .rd_addr_o  (rd_addr),
    .wr_en_o    (wr_en),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data),
    .ta_drive_o (ta_drive),
    .tx_shift_o (tx_shift),
    .st_o       (st),
    .pos_o      (pos),
    .rd_act_o   (rd_act),
    .wr_act_o   (wr_act)
  );

  mdio_page_regs #(.NUM_PAGES(NUM_PAGES)) u_regs (
    .clk_i     (mdc_i),
    .rst_ni    (rst_ni),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data)
  );

  mdio_tx_driver u_tx (
    .clk_i      (mdc_i),
    .rst_ni     (rst_ni),
    .load_i     (rd_load),
    .data_i     (rd_data),
    .ta_drive_i (ta_drive),
    .shift_i    (tx_shift),
    .oe_o       (mdio_oe_o)
  );
endmodule

// File: rtl/mdio_slave_chk.sv
module mdio_slave_chk
  import mdio_pkg::*;
(
  input logic       mdc_i,
  input logic       rst_ni,
  input logic       mdio_oe_o,
  input mdio_st_e   st,
  input logic [4:0] pos,
  input logic       rd_act,
  input logic       wr_act,
  input logic       wr_en
);
  // R10
  oe_only_in_read_chk: assert property (@(posedge mdc_i) disable iff (!rst_ni)
    mdio_oe_o |-> rd_act);

  // R3
  ta_first_released_chk: assert property (@(posedge mdc_i) disable iff (!rst_ni)
    (st == ST_BODY && pos == POS_TA_HI) |-> !mdio_oe_o);

  // R3
  ta_second_driven_chk: assert property (@(posedge mdc_i) disable iff (!rst_ni)
    (st == ST_BODY && rd_act && pos == POS_DATA_LO) |-> mdio_oe_o);

  // R4
  idle_released_chk: assert property (@(posedge mdc_i) disable iff (!rst_ni)
    (st != ST_BODY) |-> !mdio_oe_o);

  // R9
  write_ends_frame_chk: assert property (@(posedge mdc_i) disable iff (!rst_ni)
    wr_en |=> (st == ST_HUNT));

  // R6
  single_op_chk: assert property (@(posedge mdc_i) disable iff (!rst_ni)
    $onehot0({rd_act, wr_act}));
endmodule

bind mdio_slave_paged mdio_slave_chk u_chk (
  .mdc_i     (mdc_i),
  .rst_ni    (rst_ni),
  .mdio_oe_o (mdio_oe_o),
  .st        (st),
  .pos       (pos),
  .rd_act    (rd_act),
  .wr_act    (wr_act),
  .wr_en     (wr_en)
);

// File: tb/mdio_slave_paged_bench.sv
module mdio_slave_paged_bench;
  localparam int MDC_PERIOD = 40;
  localparam logic [4:0] STRAP = 5'd3;
  localparam int NV = 21;
  localparam logic RD = 1'b1;
  localparam logic WR = 1'b0;

  // {rd, phy, reg, value, preamble, requirement}
  localparam logic [36:0] VECS [NV] = '{
    {RD, 5'd3, 5'd0,  16'h0000, 6'd32, 4'd1},  // R1 reset value
    {WR, 5'd3, 5'd0,  16'hA5C3, 6'd32, 4'd2},
    {RD, 5'd3, 5'd0,  16'hA5C3, 6'd0,  4'd2},  // R2
    {WR, 5'd3, 5'd15, 16'hFFFF, 6'd1,  4'd9},
    {RD, 5'd3, 5'd15, 16'hFFFF, 6'd5,  4'd9},  // R9 short idle runs
    {WR, 5'd3, 5'd16, 16'h1234, 6'd0,  4'd7},
    {WR, 5'd3, 5'd31, 16'h0001, 6'd2,  4'd7},
    {RD, 5'd3, 5'd16, 16'h0000, 6'd2,  4'd7},  // R7 page 1 bank fresh
    {WR, 5'd3, 5'd16, 16'hBEEF, 6'd2,  4'd7},
    {RD, 5'd3, 5'd16, 16'hBEEF, 6'd2,  4'd7},
    {RD, 5'd3, 5'd0,  16'hA5C3, 6'd2,  4'd8},  // R8 shared on page 1
    {RD, 5'd3, 5'd31, 16'h0001, 6'd2,  4'd8},
    {WR, 5'd3, 5'd31, 16'h0000, 6'd2,  4'd7},
    {RD, 5'd3, 5'd16, 16'h1234, 6'd2,  4'd7},
    {WR, 5'd3, 5'd30, 16'h8001, 6'd2,  4'd3},
    {RD, 5'd3, 5'd30, 16'h8001, 6'd2,  4'd3},  // R3 turnaround
    {WR, 5'd5, 5'd0,  16'h0000, 6'd2,  4'd5},  // R5 foreign address
    {RD, 5'd3, 5'd0,  16'hA5C3, 6'd2,  4'd5},
    {RD, 5'd5, 5'd0,  16'hA5C3, 6'd2,  4'd5},
    {WR, 5'd3, 5'd1,  16'h0F0F, 6'd0,  4'd4},
    {RD, 5'd3, 5'd1,  16'h0F0F, 6'd0,  4'd4}   // R4 data shape
  };

  logic mdc = 1'b0;
  logic rst_n = 1'b0;
  logic mdio_m = 1'b1;
  logic mdio_oe;
  logic mdio_line;
  int   checks = 0;
  int   fails = 0;

  assign mdio_line = mdio_oe ? 1'b0 : mdio_m;

  always #(MDC_PERIOD/2) mdc = ~mdc;

  mdio_slave_paged u_mdio_slave_paged (
    .mdc_i      (mdc),
    .rst_ni     (rst_n),
    .mdio_i     (mdio_line),
    .phy_addr_i (STRAP),
    .mdio_oe_o  (mdio_oe)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra,
                           input logic [15:0] wd, input int pre,
                           output logic [17:0] got, output logic drove, output logic post_oe);
    logic [31:0] bits;
    bits = {2'b01, op, phy, ra, 2'b10, wd};
    if (op == 2'b10) bits[17:0] = '1;
    drove = 1'b0;
    got = '0;
    for (int i = 0; i < pre; i++) begin
      @(negedge mdc); mdio_m = 1'b1; #1; drove |= mdio_oe;
    end
    for (int i = 0; i < 32; i++) begin
      @(negedge mdc); mdio_m = bits[31-i]; #1;
      if (i >= 14) got[31-i] = mdio_line;
      if (i < 14 || op != 2'b10) drove |= mdio_oe;
    end
    @(negedge mdc); mdio_m = 1'b1; #1;
    post_oe = mdio_oe;
  endtask

  task automatic read_chk(input logic [4:0] ra, input logic [15:0] exp, input string req);
    logic [17:0] got;
    logic d, p;
    run_frame(2'b10, STRAP, ra, 16'h0, 2, got, d, p);
    check(got == {2'b10, exp}, req, 32'(got), 32'({2'b10, exp}));
    check(!d, req, 32'(d), 32'd0);
  endtask

  task automatic write_do(input logic [4:0] ra, input logic [15:0] wd, input string req);
    logic [17:0] got;
    logic d, p;
    run_frame(2'b01, STRAP, ra, wd, 2, got, d, p);
    check(!d, req, 32'(d), 32'd0);
  endtask

  initial begin
    #(MDC_PERIOD * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [17:0] got;
    logic        drove, post_oe;
    logic [17:0] exp;
    repeat (3) @(negedge mdc);
    #1;
    check(mdio_oe == 1'b0, "R1", 32'(mdio_oe), 32'd0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      logic        rd;
      logic [4:0]  phy, ra;
      logic [15:0] val;
      int          pre;
      string       req;
      rd  = VECS[v][36];
      phy = VECS[v][35:31];
      ra  = VECS[v][30:26];
      val = VECS[v][25:10];
      pre = int'(VECS[v][9:4]);
      req = $sformatf("R%0d", VECS[v][3:0]);
      run_frame(rd ? 2'b10 : 2'b01, phy, ra, val, pre, got, drove, post_oe);
      if (rd) begin
        exp = (phy == STRAP) ? {2'b10, val} : '1;
        check(got == exp, req, 32'(got), 32'(exp));
      end else begin
        check(!drove, "R10", 32'(drove), 32'd0);
      end
      check(!post_oe, "R4", 32'(post_oe), 32'd0);
    end

    // R6 reserved opcodes
    run_frame(2'b11, STRAP, 5'd0, 16'h0000, 2, got, drove, post_oe);
    check(!drove, "R6", 32'(drove), 32'd0);
    run_frame(2'b00, STRAP, 5'd0, 16'h0000, 0, got, drove, post_oe);
    check(!drove, "R6", 32'(drove), 32'd0);
    read_chk(5'd0, 16'hA5C3, "R6");

    // R8 shared register written on page 1, read on page 0
    write_do(5'd31, 16'h0001, "R8");
    write_do(5'd2, 16'hABCD, "R8");
    write_do(5'd31, 16'h0000, "R8");
    read_chk(5'd2, 16'hABCD, "R8");
    read_chk(5'd16, 16'h1234, "R7");

    // R1 asynchronous reset mid-run
    write_do(5'd31, 16'h0001, "R1");
    @(negedge mdc); rst_n = 1'b0;
    #3; rst_n = 1'b1;
    read_chk(5'd0, 16'h0000, "R1");
    read_chk(5'd31, 16'h0000, "R1");
    read_chk(5'd16, 16'h0000, "R1");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule